// File: doc/BRIEF.md
# Processor Interrupt and Reset Sequencer

This block decides, once per instruction, what an 8-bit accumulator processor core does next: run its reset sequence, take a non-maskable interrupt, take a maskable interrupt, or simply fetch the next opcode. It watches three request inputs. The first is a level reset request that cannot be masked. The second is a level maskable interrupt, gated by the first enable flag. The third is a non-maskable interrupt that reacts to a rising edge; that input is synchronised, and its edge is then latched until the core services it. The core sends strobes for the enable, disable, return-from-NMI, mode-select and halt instructions, one strobe for each completed bus cycle and one at each instruction boundary.

Pending requests are copied into a sampled set at the end of each bus cycle. The entry kind the core sees comes only from that sampled set. When the core pulses the boundary strobe, the block commits the shown entry: it updates the two enable flags, the halt state and the mode, and it drops the serviced request from the sampled set. It also gives the jump target of the entry, a hold flag that keeps the program counter from advancing, and the constant register values that the core loads during its reset sequence.

Top module: `cpu_irq_sequencer`

## Requirements
- R1: The entry kind output encodes 0 = fetch, 1 = reset, 2 = NMI, 3 = maskable IRQ. When several requests are sampled at once, reset (power-on or level) takes precedence over NMI, and NMI over IRQ. With nothing sampled the kind is 0.
- R2: The entry kind changes only on a cycle with a bus-done or boundary strobe. A request that rises or falls between bus cycles is not seen until the next bus-done strobe.
- R3: A maskable request is pending only while the IRQ line is high and enable flag 1 is set. Lowering the line or clearing the flag withdraws it at the next sample.
- R4: A rising NMI edge, after a two-flop synchroniser, latches a pending NMI. It stays pending until an NMI entry is committed. A line held high does not raise it again, and an edge that arrives during block reset is discarded.
- R5: The level reset request is pending whenever it is high, regardless of the enable flags. The power-on request set by block reset clears once one reset entry has been committed.
- R6: The enable strobe sets both enable flags and the disable strobe clears both. Flag 1 is never set while flag 2 is clear.
- R7: Committing an NMI entry copies flag 1 into flag 2 and clears flag 1. While NMI is the shown kind, the target is 0x0066.
- R8: Committing an IRQ entry clears both flags. The target shown for IRQ is 0x0038 in mode 1 and 0x0000 otherwise, and in mode 0 the PC-hold output is high.
- R9: The return-from-NMI strobe copies flag 2 into flag 1.
- R10: The mode strobe takes opcode bits 4:3. Values 00 and 01 give mode 0, 10 gives mode 1 and 11 gives mode 2, and the mode output encodes the mode as its number.
- R11: Committing a reset entry clears both flags, sets mode 0 and clears halt. The load values are PC = 0x0000, SP = 0xFFFF, A = 0xFF, F = 0xFF and I/R = 0x0000.
- R12: The halt strobe sets the halted output and PC-hold. Committing any reset, NMI or IRQ entry clears the halted state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset; also raises the power-on request |
| reset_req_i | input | 1 | Level reset request from outside |
| irq_i | input | 1 | Level maskable interrupt line |
| nmi_i | input | 1 | Non-maskable interrupt line, asynchronous, edge sensitive |
| ei_i | input | 1 | Enable-interrupts instruction strobe |
| di_i | input | 1 | Disable-interrupts instruction strobe |
| retn_i | input | 1 | Return-from-NMI instruction strobe |
| im_i | input | 1 | Mode-select instruction strobe |
| im_opcode_i | input | 8 | Opcode byte of the mode-select instruction |
| halt_i | input | 1 | Halt instruction strobe |
| bus_done_i | input | 1 | End of a bus cycle; samples the pending requests |
| boundary_i | input | 1 | Instruction boundary; commits the shown entry |
| entry_kind_o | output | 2 | Next entry: 0 fetch, 1 reset, 2 NMI, 3 IRQ |
| entry_vec_o | output | 16 | Jump target of the shown entry |
| irq_mode_o | output | 2 | Current interrupt mode |
| pc_hold_o | output | 1 | PC must not advance (halted, or IRQ in mode 0) |
| halted_o | output | 1 | Halt status |
| iff1_o | output | 1 | Enable flag 1 |
| iff2_o | output | 1 | Enable flag 2 |
| init_pc_o | output | 16 | PC value loaded by the reset sequence |
| init_sp_o | output | 16 | SP value loaded by the reset sequence |
| init_a_o | output | 8 | Accumulator value loaded by the reset sequence |
| init_f_o | output | 8 | Flag register value loaded by the reset sequence |
| init_ir_o | output | 16 | I/R pair value loaded by the reset sequence |

## Verification
The properties assume the core sends at most one of the enable, disable and return-from-NMI strobes in any cycle. They also assume that a strobe the core sends in the cycle it commits an entry may be overridden by that entry's flag update. The stimulus pulses each strobe alone for one cycle and keeps the boundary strobe apart from the instruction strobes and from bus-done. Every entry is therefore observed first in its sampled state and only then committed.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [1:0] {
        ENTRY_FETCH = 2'd0,
        ENTRY_RESET = 2'd1,
        ENTRY_NMI   = 2'd2,
        ENTRY_IRQ   = 2'd3
    } entry_e;

    typedef enum logic [1:0] {
        IMODE_0 = 2'd0,
        IMODE_1 = 2'd1,
        IMODE_2 = 2'd2
    } imode_e;

    typedef struct packed {
        logic por;
        logic lvl_rst;
        logic nmi;
        logic irq;
    } req_t;

    localparam logic [15:0] NMI_TARGET  = 16'h0066;
    localparam logic [15:0] IRQ1_TARGET = 16'h0038;

    function automatic imode_e decode_im(input logic [7:0] op);
        imode_e m;
        case (op[4:3])
            2'b10:   m = IMODE_1;
            2'b11:   m = IMODE_2;
            default: m = IMODE_0;
        endcase
        return m;
    endfunction

    function automatic entry_e pick_entry(input req_t r);
        entry_e e;
        if (r.por || r.lvl_rst)
            e = ENTRY_RESET;
        else if (r.nmi)
            e = ENTRY_NMI;
        else if (r.irq)
            e = ENTRY_IRQ;
        else
            e = ENTRY_FETCH;
        return e;
    endfunction

    function automatic req_t clear_served(input req_t r, input entry_e e);
        req_t o;
        o = r;
        case (e)
            ENTRY_RESET: begin
                o.por     = 1'b0;
                o.lvl_rst = 1'b0;
            end
            ENTRY_NMI: o.nmi = 1'b0;
            ENTRY_IRQ: o.irq = 1'b0;
            default:   o = r;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/irq_nmi_capture.sv
module irq_nmi_capture #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic nmi_i,
    output logic nmi_rise_o
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    // Preset to ones: a line already high, or rising while reset is held,
    // never produces an edge.
    always_ff @(posedge clk) begin
        if (rst)
            chain <= '1;
        else
            chain <= {chain[CHAIN_W-2:0], nmi_i};
    end

    assign nmi_rise_o = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];

endmodule

// File: rtl/irq_request_sampler.sv
module irq_request_sampler
    import irq_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   reset_req_i,
    input  logic   irq_i,
    input  logic   iff1_i,
    input  logic   nmi_rise_i,
    input  logic   bus_done_i,
    input  logic   boundary_i,
    output entry_e kind_o
);
    logic por_pend;
    logic nmi_pend;
    req_t live;
    req_t samp;
    req_t samp_next;

    assign kind_o = pick_entry(samp);

    always_comb begin
        live.por     = por_pend;
        live.lvl_rst = reset_req_i;
        live.nmi     = nmi_pend;
        live.irq     = irq_i & iff1_i;
    end

    always_comb begin
        samp_next = bus_done_i ? live : samp;
        if (boundary_i)
            samp_next = clear_served(samp_next, kind_o);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            por_pend <= 1'b1;
            nmi_pend <= 1'b0;
            samp     <= '{por: 1'b1, lvl_rst: 1'b0, nmi: 1'b0, irq: 1'b0};
        end else begin
            if (boundary_i && kind_o == ENTRY_RESET)
                por_pend <= 1'b0;
            if (nmi_rise_i)
                nmi_pend <= 1'b1;
            else if (boundary_i && kind_o == ENTRY_NMI)
                nmi_pend <= 1'b0;
            samp <= samp_next;
        end
    end

endmodule

// File: rtl/irq_enable_state.sv
module irq_enable_state
    import irq_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ei_i,
    input  logic       di_i,
    input  logic       retn_i,
    input  logic       im_i,
    input  logic [7:0] im_opcode_i,
    input  logic       halt_i,
    input  logic       commit_i,
    input  entry_e     kind_i,
    output logic       iff1_o,
    output logic       iff2_o,
    output imode_e     mode_o,
    output logic       halted_o
);
    logic take_entry;

    assign take_entry = commit_i && (kind_i != ENTRY_FETCH);

    always_ff @(posedge clk) begin
        if (rst) begin
            iff1_o   <= 1'b0;
            iff2_o   <= 1'b0;
            mode_o   <= IMODE_0;
            halted_o <= 1'b0;
        end else if (take_entry) begin
            halted_o <= 1'b0;
            case (kind_i)
                ENTRY_RESET: begin
                    iff1_o <= 1'b0;
                    iff2_o <= 1'b0;
                    mode_o <= IMODE_0;
                end
                ENTRY_NMI: begin
                    iff2_o <= iff1_o;
                    iff1_o <= 1'b0;
                end
                default: begin
                    iff1_o <= 1'b0;
                    iff2_o <= 1'b0;
                end
            endcase
        end else begin
            if (di_i) begin
                iff1_o <= 1'b0;
                iff2_o <= 1'b0;
            end else if (ei_i) begin
                iff1_o <= 1'b1;
                iff2_o <= 1'b1;
            end else if (retn_i) begin
                iff1_o <= iff2_o;
            end
            if (im_i)
                mode_o <= decode_im(im_opcode_i);
            if (halt_i)
                halted_o <= 1'b1;
        end
    end

endmodule

// File: rtl/cpu_irq_sequencer.sv
module cpu_irq_sequencer
    import irq_seq_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reset_req_i,
    input  logic              irq_i,
    input  logic              nmi_i,
    input  logic              ei_i,
    input  logic              di_i,
    input  logic              retn_i,
    input  logic              im_i,
    input  logic [7:0]        im_opcode_i,
    input  logic              halt_i,
    input  logic              bus_done_i,
    input  logic              boundary_i,
    output logic [1:0]        entry_kind_o,
    output logic [ADDR_W-1:0] entry_vec_o,
    output logic [1:0]        irq_mode_o,
    output logic              pc_hold_o,
    output logic              halted_o,
    output logic              iff1_o,
    output logic              iff2_o,
    output logic [ADDR_W-1:0] init_pc_o,
    output logic [ADDR_W-1:0] init_sp_o,
    output logic [DATA_W-1:0] init_a_o,
    output logic [DATA_W-1:0] init_f_o,
    output logic [2*DATA_W-1:0] init_ir_o
);
    entry_e kind;
    imode_e mode;
    logic   nmi_rise;
    logic   iff1;
    logic   iff2;
    logic   halted;

    irq_nmi_capture #(.SYNC_STAGES(SYNC_STAGES)) u_nmi (
        .clk        (clk),
        .rst        (rst),
        .nmi_i      (nmi_i),
        .nmi_rise_o (nmi_rise)
    );

    irq_request_sampler u_samp (
        .clk         (clk),
        .rst         (rst),
        .reset_req_i (reset_req_i),
        .irq_i       (irq_i),
        .iff1_i      (iff1),
        .nmi_rise_i  (nmi_rise),
        .bus_done_i  (bus_done_i),
        .boundary_i  (boundary_i),
        .kind_o      (kind)
    );

    irq_enable_state u_en (
        .clk         (clk),
        .rst         (rst),
        .ei_i        (ei_i),
        .di_i        (di_i),
        .retn_i      (retn_i),
        .im_i        (im_i),
        .im_opcode_i (im_opcode_i),
        .halt_i      (halt_i),
        .commit_i    (boundary_i),
        .kind_i      (kind),
        .iff1_o      (iff1),
        .iff2_o      (iff2),
        .mode_o      (mode),
        .halted_o    (halted)
    );

    always_comb begin
        case (kind)
            ENTRY_NMI: entry_vec_o = ADDR_W'(NMI_TARGET);
            ENTRY_IRQ: entry_vec_o = (mode == IMODE_1) ? ADDR_W'(IRQ1_TARGET) : '0;
            default:   entry_vec_o = '0;
        endcase
    end

    assign entry_kind_o = kind;
    assign irq_mode_o   = mode;
    assign pc_hold_o    = halted || (kind == ENTRY_IRQ && mode == IMODE_0);
    assign halted_o     = halted;
    assign iff1_o       = iff1;
    assign iff2_o       = iff2;

    assign init_pc_o = '0;
    assign init_sp_o = '1;
    assign init_a_o  = '1;
    assign init_f_o  = '1;
    assign init_ir_o = '0;

endmodule

// File: rtl/irq_seq_checker.sv
module irq_seq_checker (
    input logic       clk,
    input logic       rst,
    input logic       boundary_i,
    input logic       bus_done_i,
    input logic       ei_i,
    input logic       di_i,
    input logic       retn_i,
    input logic       halt_i,
    input logic [1:0] entry_kind_o,
    input logic [1:0] irq_mode_o,
    input logic       iff1_o,
    input logic       iff2_o,
    input logic       halted_o
);
    AST_KIND_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        (!bus_done_i && !boundary_i) |=> $stable(entry_kind_o)); // R2

    AST_FLAG_ORDER: assert property (@(posedge clk) disable iff (rst)
        iff1_o |-> iff2_o); // R6

    AST_DI_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (di_i && !boundary_i) |=> (!iff1_o && !iff2_o)); // R6

    AST_NMI_SAVE: assert property (@(posedge clk) disable iff (rst)
        (boundary_i && entry_kind_o == 2'd2) |=> (!iff1_o && iff2_o == $past(iff1_o))); // R7

    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (boundary_i && entry_kind_o == 2'd3) |=> (!iff1_o && !iff2_o)); // R8

    AST_RETN_RESTORE: assert property (@(posedge clk) disable iff (rst)
        (retn_i && !ei_i && !di_i && !boundary_i) |=> (iff1_o == $past(iff2_o))); // R9

    AST_RESET_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (boundary_i && entry_kind_o == 2'd1) |=> (!iff1_o && !iff2_o && irq_mode_o == 2'd0 && !halted_o)); // R11

    AST_HALT_SET: assert property (@(posedge clk) disable iff (rst)
        (halt_i && !boundary_i) |=> halted_o); // R12

    AST_ENTRY_WAKES: assert property (@(posedge clk) disable iff (rst)
        (boundary_i && entry_kind_o != 2'd0) |=> !halted_o); // R12

endmodule

bind cpu_irq_sequencer irq_seq_checker u_irq_chk (
    .clk          (clk),
    .rst          (rst),
    .boundary_i   (boundary_i),
    .bus_done_i   (bus_done_i),
    .ei_i         (ei_i),
    .di_i         (di_i),
    .retn_i       (retn_i),
    .halt_i       (halt_i),
    .entry_kind_o (entry_kind_o),
    .irq_mode_o   (irq_mode_o),
    .iff1_o       (iff1_o),
    .iff2_o       (iff2_o),
    .halted_o     (halted_o)
);

// File: tb/cpu_irq_sequencer_bench.sv
module cpu_irq_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reset_req_i = 1'b0;
    logic        irq_i = 1'b0;
    logic        nmi_i = 1'b0;
    logic        ei_i = 1'b0;
    logic        di_i = 1'b0;
    logic        retn_i = 1'b0;
    logic        im_i = 1'b0;
    logic [7:0]  im_opcode_i = 8'h00;
    logic        halt_i = 1'b0;
    logic        bus_done_i = 1'b0;
    logic        boundary_i = 1'b0;
    logic [1:0]  entry_kind_o;
    logic [15:0] entry_vec_o;
    logic [1:0]  irq_mode_o;
    logic        pc_hold_o;
    logic        halted_o;
    logic        iff1_o;
    logic        iff2_o;
    logic [15:0] init_pc_o;
    logic [15:0] init_sp_o;
    logic [7:0]  init_a_o;
    logic [7:0]  init_f_o;
    logic [15:0] init_ir_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    cpu_irq_sequencer u_cpu_irq_sequencer (
        .clk(clk), .rst(rst), .reset_req_i(reset_req_i), .irq_i(irq_i), .nmi_i(nmi_i),
        .ei_i(ei_i), .di_i(di_i), .retn_i(retn_i), .im_i(im_i), .im_opcode_i(im_opcode_i),
        .halt_i(halt_i), .bus_done_i(bus_done_i), .boundary_i(boundary_i),
        .entry_kind_o(entry_kind_o), .entry_vec_o(entry_vec_o), .irq_mode_o(irq_mode_o),
        .pc_hold_o(pc_hold_o), .halted_o(halted_o), .iff1_o(iff1_o), .iff2_o(iff2_o),
        .init_pc_o(init_pc_o), .init_sp_o(init_sp_o), .init_a_o(init_a_o),
        .init_f_o(init_f_o), .init_ir_o(init_ir_o)
    );

    always #2 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_cycle();
        bus_done_i = 1'b1; tick(1); bus_done_i = 1'b0;
    endtask

    task automatic commit();
        boundary_i = 1'b1; tick(1); boundary_i = 1'b0;
    endtask

    task automatic strobe_ei();   ei_i = 1'b1;   tick(1); ei_i = 1'b0;   endtask
    task automatic strobe_di();   di_i = 1'b1;   tick(1); di_i = 1'b0;   endtask
    task automatic strobe_retn(); retn_i = 1'b1; tick(1); retn_i = 1'b0; endtask
    task automatic strobe_halt(); halt_i = 1'b1; tick(1); halt_i = 1'b0; endtask

    task automatic set_mode(input logic [7:0] op);
        im_opcode_i = op; im_i = 1'b1; tick(1); im_i = 1'b0;
    endtask

    task automatic t_power_on();
        chk("R5 power-on kind", entry_kind_o, 2'd1);
        chk("R11 iff1 after reset", iff1_o, 1'b0);
        chk("R11 iff2 after reset", iff2_o, 1'b0);
        chk("R11 mode after reset", irq_mode_o, 2'd0);
        chk("R11 halted after reset", halted_o, 1'b0);
        chk("R11 init pc", init_pc_o, 16'h0000);
        chk("R11 init sp", init_sp_o, 16'hFFFF);
        chk("R11 init a", init_a_o, 8'hFF);
        chk("R11 init f", init_f_o, 8'hFF);
        chk("R11 init ir", init_ir_o, 16'h0000);
        commit();
        chk("R5 power-on served", entry_kind_o, 2'd0);
        bus_cycle();
        chk("R5 power-on not repeated", entry_kind_o, 2'd0);
    endtask

    task automatic t_sampling();
        reset_req_i = 1'b1;
        tick(3);
        chk("R2 live change unseen", entry_kind_o, 2'd0);
        bus_cycle();
        chk("R5 level reset sampled", entry_kind_o, 2'd1);
        commit();
        chk("R2 served reset dropped", entry_kind_o, 2'd0);
        bus_cycle();
        chk("R5 level reset still pending", entry_kind_o, 2'd1);
        reset_req_i = 1'b0;
        tick(2);
        chk("R2 drop unseen before bus cycle", entry_kind_o, 2'd1);
        bus_cycle();
        chk("R5 level reset withdrawn", entry_kind_o, 2'd0);
    endtask

    task automatic t_masking();
        irq_i = 1'b1;
        bus_cycle();
        chk("R3 masked irq", entry_kind_o, 2'd0);
        strobe_ei();
        chk("R6 ei sets iff1", iff1_o, 1'b1);
        chk("R6 ei sets iff2", iff2_o, 1'b1);
        bus_cycle();
        chk("R3 irq pending", entry_kind_o, 2'd3);
        irq_i = 1'b0;
        bus_cycle();
        chk("R3 irq withdrawn by line", entry_kind_o, 2'd0);
        irq_i = 1'b1;
        bus_cycle();
        chk("R3 irq pending again", entry_kind_o, 2'd3);
        strobe_di();
        chk("R6 di clears iff1", iff1_o, 1'b0);
        chk("R6 di clears iff2", iff2_o, 1'b0);
        bus_cycle();
        chk("R3 irq withdrawn by di", entry_kind_o, 2'd0);
        irq_i = 1'b0;
    endtask

    task automatic t_modes();
        set_mode(8'h56);
        chk("R10 bits 10 mode 1", irq_mode_o, 2'd1);
        set_mode(8'h5E);
        chk("R10 bits 11 mode 2", irq_mode_o, 2'd2);
        set_mode(8'h4E);
        chk("R10 bits 01 mode 0", irq_mode_o, 2'd0);
        set_mode(8'h56);
        set_mode(8'h46);
        chk("R10 bits 00 mode 0", irq_mode_o, 2'd0);
        set_mode(8'h56);
        strobe_ei();
        irq_i = 1'b1;
        bus_cycle();
        chk("R8 irq kind mode 1", entry_kind_o, 2'd3);
        chk("R8 mode 1 target", entry_vec_o, 16'h0038);
        chk("R8 mode 1 no hold", pc_hold_o, 1'b0);
        commit();
        chk("R8 entry clears iff1", iff1_o, 1'b0);
        chk("R8 entry clears iff2", iff2_o, 1'b0);
        chk("R8 served irq dropped", entry_kind_o, 2'd0);
        set_mode(8'h46);
        strobe_ei();
        bus_cycle();
        chk("R8 irq kind mode 0", entry_kind_o, 2'd3);
        chk("R8 mode 0 target", entry_vec_o, 16'h0000);
        chk("R8 mode 0 hold", pc_hold_o, 1'b1);
        commit();
        irq_i = 1'b0;
    endtask

    task automatic t_nmi();
        strobe_ei();
        nmi_i = 1'b1;
        tick(4);
        bus_cycle();
        chk("R4 nmi latched", entry_kind_o, 2'd2);
        chk("R7 nmi target", entry_vec_o, 16'h0066);
        commit();
        chk("R7 nmi clears iff1", iff1_o, 1'b0);
        chk("R7 nmi saves iff1 in iff2", iff2_o, 1'b1);
        tick(4);
        bus_cycle();
        chk("R4 held line no retrigger", entry_kind_o, 2'd0);
        strobe_retn();
        chk("R9 retn restores iff1", iff1_o, 1'b1);
        nmi_i = 1'b0;
        tick(4);
        // all three requests together
        irq_i = 1'b1;
        reset_req_i = 1'b1;
        nmi_i = 1'b1;
        tick(4);
        bus_cycle();
        chk("R1 reset beats nmi and irq", entry_kind_o, 2'd1);
        reset_req_i = 1'b0;
        bus_cycle();
        chk("R1 nmi beats irq", entry_kind_o, 2'd2);
        commit();
        bus_cycle();
        chk("R3 irq masked after nmi entry", entry_kind_o, 2'd0);
        strobe_retn();
        bus_cycle();
        chk("R1 irq after nmi served", entry_kind_o, 2'd3);
        commit();
        irq_i = 1'b0;
        nmi_i = 1'b0;
        tick(4);
    endtask

    task automatic t_halt();
        strobe_halt();
        chk("R12 halted set", halted_o, 1'b1);
        chk("R12 halt holds pc", pc_hold_o, 1'b1);
        set_mode(8'h56);
        strobe_ei();
        irq_i = 1'b1;
        bus_cycle();
        commit();
        chk("R12 irq entry wakes", halted_o, 1'b0);
        irq_i = 1'b0;
        strobe_halt();
        nmi_i = 1'b1;
        tick(4);
        bus_cycle();
        commit();
        chk("R12 nmi entry wakes", halted_o, 1'b0);
        nmi_i = 1'b0;
        tick(4);
    endtask

    task automatic t_nmi_in_reset();
        rst = 1'b1;
        tick(1);
        nmi_i = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(5);
        chk("R5 power-on after reset", entry_kind_o, 2'd1);
        commit();
        bus_cycle();
        chk("R4 edge in reset discarded", entry_kind_o, 2'd0);
        nmi_i = 1'b0;
        tick(3);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        t_power_on();
        t_sampling();
        t_masking();
        t_modes();
        t_nmi();
        t_halt();
        t_nmi_in_reset();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule